// File: doc/BRIEF.md
# Background Pixel Shifter with Fine Scroll

This block converts tile data, as a fetch sequencer delivers it, into one 4-bit background palette index on every pixel clock. Each pattern bit plane has its own 16-bit shift register. Each of the two palette-select bits has its own 8-bit shift register. All four registers advance one position on every clock. A 3-bit fine horizontal scroll value chooses a tap. That tap reads the same relative position in all four registers, and the four bits it picks form the output index.

The sequencer pulses `loadStrobe` in the last cycle of a tile's 8-cycle fetch slot. It presents the tile's two pattern bytes and its 2-bit palette select in that same cycle. On the clock edge that ends the strobe cycle, each pattern register shifts one place toward its MSB and then takes the new byte in its low half. There is no second shift in that cycle. The palette select is held in a small latch that refills the palette registers on every shift. All eight pixels of a tile therefore carry its palette.

The registers shift toward the MSB, so bit 7 of a pattern byte, the leftmost pixel, reaches the tap first. With fine scroll n, the first pixel of a tile appears 16 − n cycles after its fetch slot starts.

Top module: `bgPixelShifter`

## Requirements
- R1: Between loads, each pattern register moves one bit toward its MSB on every clock and takes 0 into bit 0. Successive pixels of a tile therefore appear on consecutive cycles, from byte bit 7 down to bit 0.
- R2: On a clock edge with `loadStrobe` high, each pattern register first shifts by one and then its low byte is replaced by the input byte. Its upper byte holds the previous bits 14..7. No further shift happens on that edge.
- R3: The palette latch captures `tilePal` only on a load edge and otherwise keeps its value. Each palette register shifts toward its MSB on every clock, and its bit 0 takes the latched value.
- R4: Fine scroll n (0..7) selects bit 15 − n of both pattern registers and bit 7 − n of both palette registers.
- R5: Output encoding: `pixelIdx[0]` comes from plane 0, `pixelIdx[1]` from plane 1, `pixelIdx[2]` from palette bit 0 and `pixelIdx[3]` from palette bit 1.
- R6: If the fetch slot starts in cycle 0 and `loadStrobe` is high in cycle 7, the tile's leftmost pixel (pattern bit 7) is on `pixelIdx` in cycle 16 − n.
- R7: The tile's palette select enters bit 0 of the palette registers in cycle 9 of the slot. All eight of the tile's pixels carry that palette, including the last one in cycle 23 − n.
- R8: A synchronous reset clears all four shift registers and the palette latch. In the cycle after a reset edge, `pixelIdx` is 0, and it stays 0 until the next load reaches the tap.
- R9: While `renderEn` is low, `pixelIdx` is 0. Shifting and loading continue, so output that follows re-enabling is the same as if rendering had never stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| renderEn | input | 1 | Background rendering enable; when low the output is forced to 0 |
| loadStrobe | input | 1 | High in the final cycle of a tile fetch slot |
| tilePlane0 | input | 8 | Pattern byte for bit plane 0, bit 7 = leftmost pixel |
| tilePlane1 | input | 8 | Pattern byte for bit plane 1, bit 7 = leftmost pixel |
| tilePal | input | 2 | Palette select of the tile being loaded |
| fineX | input | 3 | Fine horizontal scroll, 0..7 |
| pixelIdx | output | 4 | Background palette index of the current pixel |

## Verification
Properties hold on every cycle for the following:
- A load writes the presented bytes into the low half of each pattern register.
- The palette latch changes only on a load.
- Clear and load strobes never coincide.
- The output is zero after a reset edge and whenever rendering is off.

Three behaviours can be shown only by the bench's streams of tiles at several scroll values:
- the end-to-end latency of 16 − n;
- the left-to-right pixel order;
- the alignment of each tile's palette with its eight pixels, including the pixel on which one tile's palette hands over to the next.

// File: rtl/bgshift_pkg.sv
package bgshift_pkg;
  localparam int TILE_W    = 8;
  localparam int PAT_W     = 2 * TILE_W;
  localparam int PLANES    = 2;
  localparam int PAL_BITS  = 2;
  localparam int TAP_W     = $clog2(TILE_W);
  localparam int PAT_IDX_W = $clog2(PAT_W);
  localparam int IDX_W     = PLANES + PAL_BITS;

  typedef struct packed {
    logic                 clear;
    logic                 load;
    logic [PAT_IDX_W-1:0] patTap;
    logic [TAP_W-1:0]     palTap;
  } shiftCtl_t;
endpackage

// File: rtl/bgshift_ctrl.sv
module bgshift_ctrl
  import bgshift_pkg::*;
(
  input  logic             rst,
  input  logic             loadStrobe,
  input  logic [TAP_W-1:0] fineX,
  output shiftCtl_t        ctl
);
  // Reset wins over load; taps count down from the MSB end of each register.
  always_comb begin
    ctl.clear  = rst;
    ctl.load   = loadStrobe & ~rst;
    ctl.patTap = PAT_IDX_W'(PAT_W - 1) - PAT_IDX_W'(fineX);
    ctl.palTap = TAP_W'(TILE_W - 1) - fineX;
  end
endmodule

// File: rtl/bgshift_dp.sv
module bgshift_dp
  import bgshift_pkg::*;
(
  input  logic                           clk,
  input  shiftCtl_t                      ctl,
  input  logic [PLANES-1:0][TILE_W-1:0]  patIn,
  input  logic [PAL_BITS-1:0]            palIn,
  input  logic                           renderEn,
  output logic [IDX_W-1:0]               pixelIdx
);
  logic [PAL_BITS-1:0] palLatch;
  logic [PLANES-1:0]   patBit;
  logic [PAL_BITS-1:0] palBit;

  always_ff @(posedge clk) begin
    if (ctl.clear)     palLatch <= '0;
    else if (ctl.load) palLatch <= palIn;
  end

  // R3
  pal_latch_hold_chk: assert property (@(posedge clk) disable iff (ctl.clear)
    !ctl.load |=> $stable(palLatch));

  // R2
  strobe_exclusive_chk: assert property (@(posedge clk)
    $onehot0({ctl.clear, ctl.load}));

  for (genvar g = 0; g < PLANES; g++) begin : gPat
    logic [PAT_W-1:0] patSr;
    always_ff @(posedge clk) begin
      if (ctl.clear)     patSr <= '0;
      else if (ctl.load) patSr <= {patSr[PAT_W-2:TILE_W-1], patIn[g]};
      else               patSr <= {patSr[PAT_W-2:0], 1'b0};
    end
    assign patBit[g] = patSr[ctl.patTap];

    // R2
    load_low_byte_chk: assert property (@(posedge clk) disable iff (ctl.clear)
      ctl.load |=> patSr[TILE_W-1:0] == $past(patIn[g]));
  end

  for (genvar h = 0; h < PAL_BITS; h++) begin : gPal
    logic [TILE_W-1:0] palSr;
    always_ff @(posedge clk) begin
      if (ctl.clear) palSr <= '0;
      else           palSr <= {palSr[TILE_W-2:0], palLatch[h]};
    end
    assign palBit[h] = palSr[ctl.palTap];
  end

  assign pixelIdx = renderEn ? {palBit, patBit} : '0;

  // R9
  blank_when_off_chk: assert property (@(posedge clk) disable iff (ctl.clear)
    !renderEn |-> pixelIdx == '0);
endmodule

// File: rtl/bgPixelShifter.sv
module bgPixelShifter
  import bgshift_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              renderEn,
  input  logic              loadStrobe,
  input  logic [TILE_W-1:0] tilePlane0,
  input  logic [TILE_W-1:0] tilePlane1,
  input  logic [PAL_BITS-1:0] tilePal,
  input  logic [TAP_W-1:0]  fineX,
  output logic [IDX_W-1:0]  pixelIdx
);
  shiftCtl_t ctl;

  bgshift_ctrl i_ctrl (
    .rst        (rst),
    .loadStrobe (loadStrobe),
    .fineX      (fineX),
    .ctl        (ctl)
  );

  bgshift_dp i_dp (
    .clk      (clk),
    .ctl      (ctl),
    .patIn    ({tilePlane1, tilePlane0}),
    .palIn    (tilePal),
    .renderEn (renderEn),
    .pixelIdx (pixelIdx)
  );

  // R8
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> pixelIdx == '0);
endmodule

// File: tb/test_bgPixelShifter.sv
module test_bgPixelShifter;
  localparam int NT = 6;
  // {palette[1:0], plane1[7:0], plane0[7:0]}
  localparam logic [17:0] TILES [NT] = '{
    {2'b01, 8'hA5, 8'h3C},
    {2'b10, 8'h0F, 8'hF0},
    {2'b11, 8'h81, 8'h7E},
    {2'b00, 8'hFF, 8'h01},
    {2'b10, 8'h55, 8'hAA},
    {2'b01, 8'hC3, 8'h96}
  };
  localparam logic [2:0] RUN_FX [4] = '{3'd0, 3'd3, 3'd5, 3'd7};

  logic clk = 0, rst = 1, renderEn = 1, loadStrobe = 0;
  logic [7:0] tilePlane0 = 0, tilePlane1 = 0;
  logic [1:0] tilePal = 0;
  logic [2:0] fineX = 0;
  logic [3:0] pixelIdx;

  int nRun = 0, nFail = 0;
  bit finished = 0;
  logic [17:0] tileMem [NT];
  string forcedTag = "";

  always #4 clk = ~clk;

  bgPixelShifter i_bgPixelShifter (
    .clk(clk), .rst(rst), .renderEn(renderEn), .loadStrobe(loadStrobe),
    .tilePlane0(tilePlane0), .tilePlane1(tilePlane1), .tilePal(tilePal),
    .fineX(fineX), .pixelIdx(pixelIdx)
  );

  task automatic check(string tag, int cyc, logic [3:0] got, logic [3:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: cycle %0d got %0h expected %0h", tag, cyc, got, exp);
    end
  endtask

  task automatic doReset();
    rst = 1; loadStrobe = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  // Stream all tiles at scroll fx; rendering off for cycles [offLo, offHi).
  task automatic runStream(int fx, int offLo, int offHi);
    fineX = 3'(fx);
    doReset();
    for (int c = 0; c < NT * 8 + 24; c++) begin
      int k = c / 8;
      int q = c - 16 + fx;
      logic [17:0] t;
      logic [3:0] exp;
      string tagP, tagA;
      t = (k < NT) ? tileMem[k] : 18'd0;
      tilePal = t[17:16]; tilePlane1 = t[15:8]; tilePlane0 = t[7:0];
      loadStrobe = (c % 8 == 7);
      renderEn = !(c >= offLo && c < offHi);
      exp = 4'd0;
      if (q >= 0) begin
        int tk = q / 8;
        int p = q % 8;
        logic [17:0] tt;
        tt = (tk < NT) ? tileMem[tk] : 18'd0;
        exp = {tt[17:16], tt[8 + 7 - p], tt[7 - p]};
        tagP = (p == 0) ? "R6" : (c % 8 == 0) ? "R2" : (fx != 0) ? "R4" : "R1";
        tagA = (p == 7) ? "R7" : "R3";
      end else begin
        tagP = "R8"; tagA = "R8";
      end
      if (!renderEn) begin exp = 4'd0; tagP = "R9"; tagA = "R9"; end
      if (forcedTag != "") begin tagP = forcedTag; tagA = forcedTag; end
      #1;
      check(tagP, c, {2'b00, pixelIdx[1:0]}, {2'b00, exp[1:0]});
      check(tagA, c, {pixelIdx[3:2], 2'b00}, {exp[3:2], 2'b00});
      @(negedge clk);
    end
    loadStrobe = 0; renderEn = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // Reset state (R8)
    doReset();
    #1 check("R8", 0, pixelIdx, 4'd0);
    @(negedge clk);

    // Vector table walked at several scroll values (R1..R4, R6, R7)
    for (int i = 0; i < NT; i++) tileMem[i] = TILES[i];
    for (int r = 0; r < 4; r++) runStream(int'(RUN_FX[r]), -1, -1);

    // R5: field positions of the index
    for (int i = 0; i < NT; i++) tileMem[i] = 18'd0;
    tileMem[0] = {2'b10, 8'h00, 8'h80};
    tileMem[1] = {2'b01, 8'h80, 8'h00};
    forcedTag = "R5";
    runStream(0, -1, -1);
    forcedTag = "";

    // R9: blanking does not stop the shifter
    for (int i = 0; i < NT; i++) tileMem[i] = TILES[i];
    runStream(2, 20, 29);

    // R8: reset in mid-stream clears registers and palette latch
    fineX = 3'd0;
    doReset();
    for (int c = 0; c < 20; c++) begin
      tilePal = 2'b11; tilePlane0 = 8'hFF; tilePlane1 = 8'hFF;
      loadStrobe = (c % 8 == 7);
      @(negedge clk);
    end
    loadStrobe = 0;
    rst = 1;
    @(negedge clk);
    rst = 0;
    for (int c = 0; c < 12; c++) begin
      #1 check("R8", c, pixelIdx, 4'd0);
      @(negedge clk);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule